// File: doc/BRIEF.md
# Runahead Mode Entry and Exit Controller

This block decides when a core leaves normal execution and starts running ahead, and when it comes back. Each cycle it looks at the oldest entry of the instruction window. If that entry is a load that missed in the second-level cache and the core is in normal mode, the block removes the load from the window and marks the load's destination register invalid. In the same cycle it takes a snapshot of the register file, the branch history and the return-address stack, and it records the load's PC, address and fill tag.

While running ahead, the block waits for the memory fill that carries the recorded tag. Fills with other tags are ignored. When the matching fill arrives, the block runs a fixed three-step exit. The first cycle flushes the pipeline, clears every invalid marker and empties the runahead store cache. The second cycle restores the snapshot. The third cycle redirects fetch to the PC of the load that caused the episode.

The fill return is a valid-qualified event stream that the block accepts in every cycle. There is no ready signal and no back-pressure, and a fill that does not match is dropped. All other pins are plain control or status lines.

Top module: `ra_mode_ctrl`

## Requirements
- R1: `head_pop` rises only in normal mode, and only when `head_valid`, `head_is_load` and `head_l2_miss` are all 1 in that cycle. Any other head pattern leaves the block in normal mode.
- R2: In the entry cycle, `head_pop`, `ckpt_save` and `dest_inv_valid` are 1 together, combinationally, and `dest_inv_idx` equals `head_dest`.
- R3: The checkpoint is the value of `arch_regs_in`, `ghr_in` and `ras_in` in the entry cycle. `ckpt_valid` is 1 from the cycle after entry until the restore cycle, and it is 0 from the cycle after restore.
- R4: From the cycle after entry, `miss_addr` shows the `head_addr` of the load that caused the episode, and it holds that value while the block runs ahead.
- R5: Only a fill with `fill_valid`=1 and `fill_tag` equal to the recorded tag ends runahead. A fill in the entry cycle itself, or a fill with any other tag, is ignored.
- R6: In the cycle after the matching fill, `flush_pipe`, `clear_inv` and `flush_ra_cache` are 1 for exactly one cycle.
- R7: In the cycle after the flush, `restore_valid` is 1 for one cycle, and `restore_regs`, `restore_ghr` and `restore_ras` carry the checkpoint.
- R8: In the cycle after the restore, `redirect_valid` is 1 for one cycle and `redirect_pc` is the PC of the causing load.
- R9: `runahead_mode` is 1 from the cycle after entry through the redirect cycle, and it is 0 in the cycle after the redirect.
- R10: While `runahead_mode` is 1, no new episode starts, even if the window head shows another missing load.
- R11: After reset the block is in normal mode, `ckpt_valid` is 0 and no pulse output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | 1 | The window head holds an instruction |
| head_is_load | input | 1 | The head instruction is a load |
| head_l2_miss | input | 1 | The head load missed in L2 |
| head_pc | input | PC_W | PC of the head instruction |
| head_addr | input | ADDR_W | Memory address of the head load |
| head_tag | input | TAG_W | Miss tag of the head load |
| head_dest | input | RIDX_W | Destination register of the head load |
| arch_regs_in | input | NREGS*DATA_W | Current architectural register values |
| ghr_in | input | GHR_W | Current branch history register |
| ras_in | input | RAS_DEPTH*PC_W | Current return-address stack |
| fill_valid | input | 1 | A memory fill is returning |
| fill_tag | input | TAG_W | Tag of the returning fill |
| head_pop | output | 1 | Remove the head load from the window |
| dest_inv_valid | output | 1 | Mark a destination register invalid |
| dest_inv_idx | output | RIDX_W | Register to mark invalid |
| ckpt_save | output | 1 | The checkpoint is being captured |
| ckpt_valid | output | 1 | A checkpoint is held |
| runahead_mode | output | 1 | The core is in runahead mode |
| miss_addr | output | ADDR_W | Recorded address of the causing load |
| flush_pipe | output | 1 | Flush all instructions in flight |
| clear_inv | output | 1 | Clear all invalid markers |
| flush_ra_cache | output | 1 | Empty the runahead store cache |
| restore_valid | output | 1 | Restore the checkpoint this cycle |
| restore_regs | output | NREGS*DATA_W | Checkpointed register values |
| restore_ghr | output | GHR_W | Checkpointed branch history |
| restore_ras | output | RAS_DEPTH*PC_W | Checkpointed return-address stack |
| redirect_valid | output | 1 | Redirect fetch this cycle |
| redirect_pc | output | PC_W | PC at which fetch restarts |

## Verification
Two events can land in the same cycle. The first is the entry request together with a fill that carries the same tag. The bench drives both at once and expects the block to enter runahead, ignore that fill and stay in runahead until a later matching fill arrives. The second is a missing load at the window head while the block is already running ahead, including the cycle in which the matching fill arrives. The bench keeps the head asserted through the episode, and any extra pop or checkpoint seen by the scoreboard monitor counts as a failure. The monitor also compares the order and content of the flush, restore and redirect pulses against the sequence queued by the driver.

// File: rtl/ra_ctrl_pkg.sv
package ra_ctrl_pkg;
  typedef enum logic [2:0] {
    RA_NORMAL  = 3'd0,
    RA_RUN     = 3'd1,
    RA_FLUSH   = 3'd2,
    RA_RESTORE = 3'd3,
    RA_REDIR   = 3'd4
  } ra_state_e;
endpackage

// File: rtl/ra_entry_detect.sv
module ra_entry_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic in_runahead,
  input  logic head_valid,
  input  logic head_is_load,
  input  logic head_l2_miss,
  output logic enter
);
  // Entry qualifies only on an L2-missing load at the head, and only in normal mode.
  always_comb enter = !in_runahead && head_valid && head_is_load && head_l2_miss;

  // R1: after an entry the block is in runahead mode.
  p_enter_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> in_runahead);
endmodule

// File: rtl/ra_ckpt_store.sv
module ra_ckpt_store #(
  parameter int PC_W   = 32,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 6,
  parameter int SNAP_W = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save,
  input  logic              release_i,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic [SNAP_W-1:0] snap_in,
  output logic              valid,
  output logic [PC_W-1:0]   rec_pc,
  output logic [ADDR_W-1:0] rec_addr,
  output logic [TAG_W-1:0]  rec_tag,
  output logic [SNAP_W-1:0] rec_snap
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      rec_pc   <= '0;
      rec_addr <= '0;
      rec_tag  <= '0;
      rec_snap <= '0;
    end else if (save) begin
      valid    <= 1'b1;
      rec_pc   <= pc_in;
      rec_addr <= addr_in;
      rec_tag  <= tag_in;
      rec_snap <= snap_in;
    end else if (release_i) begin
      valid <= 1'b0;
    end
  end

  // R3: a save leaves a valid checkpoint holding the captured snapshot.
  p_ckpt_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    save |=> valid && rec_snap == $past(snap_in));
  // R4: the recorded address is the one seen in the save cycle.
  p_addr_rec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    save |=> rec_addr == $past(addr_in));
  // R3: a release drops the checkpoint.
  p_ckpt_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    release_i && !save |=> !valid);
endmodule

// File: rtl/ra_exit_seq.sv
module ra_exit_seq
  import ra_ctrl_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enter,
  input  logic             fill_valid,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [TAG_W-1:0] rec_tag,
  output logic             mode,
  output logic             flush,
  output logic             restore,
  output logic             redirect
);
  ra_state_e state, state_nx;
  logic      hit;

  always_comb hit = fill_valid && (fill_tag == rec_tag);

  always_comb begin
    state_nx = state;
    unique case (state)
      RA_NORMAL:  if (enter) state_nx = RA_RUN;
      RA_RUN:     if (hit) state_nx = RA_FLUSH;
      RA_FLUSH:   state_nx = RA_RESTORE;
      RA_RESTORE: state_nx = RA_REDIR;
      RA_REDIR:   state_nx = RA_NORMAL;
      default:    state_nx = RA_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= RA_NORMAL;
    else        state <= state_nx;
  end

  always_comb begin
    mode     = (state != RA_NORMAL);
    flush    = (state == RA_FLUSH);
    restore  = (state == RA_RESTORE);
    redirect = (state == RA_REDIR);
  end

  // R5: with no fill, runahead is held.
  p_hold_nofill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RA_RUN && !fill_valid) |=> state == RA_RUN);
  // R5: a fill with the wrong tag is ignored.
  p_ignore_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RA_RUN && fill_valid && fill_tag != rec_tag) |=> state == RA_RUN);
  // R6: the flush lasts one cycle and is followed by the restore.
  p_flush_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush && restore);
  // R8: the restore is followed by the redirect.
  p_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> redirect);
  // R9: the mode drops right after the redirect.
  p_mode_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !mode);
  // R10: runahead mode never returns to normal mode except through the redirect.
  p_no_reentry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !redirect) |=> mode);
endmodule

// File: rtl/ra_mode_ctrl.sv
module ra_mode_ctrl #(
  parameter int PC_W      = 32,
  parameter int ADDR_W    = 32,
  parameter int TAG_W     = 6,
  parameter int RIDX_W    = 5,
  parameter int NREGS     = 8,
  parameter int DATA_W    = 32,
  parameter int GHR_W     = 16,
  parameter int RAS_DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      head_valid,
  input  logic                      head_is_load,
  input  logic                      head_l2_miss,
  input  logic [PC_W-1:0]           head_pc,
  input  logic [ADDR_W-1:0]         head_addr,
  input  logic [TAG_W-1:0]          head_tag,
  input  logic [RIDX_W-1:0]         head_dest,
  input  logic [NREGS*DATA_W-1:0]   arch_regs_in,
  input  logic [GHR_W-1:0]          ghr_in,
  input  logic [RAS_DEPTH*PC_W-1:0] ras_in,
  input  logic                      fill_valid,
  input  logic [TAG_W-1:0]          fill_tag,
  output logic                      head_pop,
  output logic                      dest_inv_valid,
  output logic [RIDX_W-1:0]         dest_inv_idx,
  output logic                      ckpt_save,
  output logic                      ckpt_valid,
  output logic                      runahead_mode,
  output logic [ADDR_W-1:0]         miss_addr,
  output logic                      flush_pipe,
  output logic                      clear_inv,
  output logic                      flush_ra_cache,
  output logic                      restore_valid,
  output logic [NREGS*DATA_W-1:0]   restore_regs,
  output logic [GHR_W-1:0]          restore_ghr,
  output logic [RAS_DEPTH*PC_W-1:0] restore_ras,
  output logic                      redirect_valid,
  output logic [PC_W-1:0]           redirect_pc
);
  localparam int REGS_W = NREGS * DATA_W;
  localparam int RAS_W  = RAS_DEPTH * PC_W;
  localparam int SNAP_W = REGS_W + GHR_W + RAS_W;

  logic              enter, mode, flush, restore, redirect;
  logic [TAG_W-1:0]  rec_tag;
  logic [SNAP_W-1:0] rec_snap;

  ra_entry_detect u_detect (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_runahead  (mode),
    .head_valid   (head_valid),
    .head_is_load (head_is_load),
    .head_l2_miss (head_l2_miss),
    .enter        (enter)
  );

  ra_ckpt_store #(
    .PC_W   (PC_W),
    .ADDR_W (ADDR_W),
    .TAG_W  (TAG_W),
    .SNAP_W (SNAP_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .save      (enter),
    .release_i (restore),
    .pc_in     (head_pc),
    .addr_in   (head_addr),
    .tag_in    (head_tag),
    .snap_in   ({arch_regs_in, ghr_in, ras_in}),
    .valid     (ckpt_valid),
    .rec_pc    (redirect_pc),
    .rec_addr  (miss_addr),
    .rec_tag   (rec_tag),
    .rec_snap  (rec_snap)
  );

  ra_exit_seq #(.TAG_W(TAG_W)) u_exit (
    .clk        (clk),
    .rst_n      (rst_n),
    .enter      (enter),
    .fill_valid (fill_valid),
    .fill_tag   (fill_tag),
    .rec_tag    (rec_tag),
    .mode       (mode),
    .flush      (flush),
    .restore    (restore),
    .redirect   (redirect)
  );

  always_comb begin
    head_pop       = enter;
    ckpt_save      = enter;
    dest_inv_valid = enter;
    dest_inv_idx   = head_dest;
    runahead_mode  = mode;
    flush_pipe     = flush;
    clear_inv      = flush;
    flush_ra_cache = flush;
    restore_valid  = restore;
    redirect_valid = redirect;
    restore_regs   = rec_snap[SNAP_W-1 -: REGS_W];
    restore_ghr    = rec_snap[RAS_W +: GHR_W];
    restore_ras    = rec_snap[RAS_W-1:0];
  end

  // R7: the checkpoint is still held when it is restored.
  p_restore_ckpt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |-> ckpt_valid);
  // R10: no second checkpoint is taken while running ahead.
  p_single_episode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    runahead_mode |-> !ckpt_save);
endmodule

// File: tb/ra_mode_ctrl_test.sv
module ra_mode_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic head_valid = 0, head_is_load = 0, head_l2_miss = 0;
  logic [31:0]  head_pc = 0, head_addr = 0;
  logic [5:0]   head_tag = 0;
  logic [4:0]   head_dest = 0;
  logic [255:0] arch_regs_in = 0;
  logic [15:0]  ghr_in = 0;
  logic [127:0] ras_in = 0;
  logic fill_valid = 0;
  logic [5:0] fill_tag = 0;
  logic head_pop, dest_inv_valid, ckpt_save, ckpt_valid, runahead_mode;
  logic [4:0] dest_inv_idx;
  logic [31:0] miss_addr, redirect_pc;
  logic flush_pipe, clear_inv, flush_ra_cache, restore_valid, redirect_valid;
  logic [255:0] restore_regs;
  logic [15:0]  restore_ghr;
  logic [127:0] restore_ras;

  ra_mode_ctrl uut (.*);

  int checks = 0, errors = 0;
  int exp_kind[$];
  logic [511:0] exp_data[$];

  // Event kinds: 1 entry (R2), 2 flush (R6), 3 restore (R7), 4 redirect (R8).
  task automatic sb_compare(input int kind, input logic [511:0] got, input string req);
    int k;
    logic [511:0] d;
    checks++;
    if (exp_kind.size() == 0) begin
      errors++;
      $display("FAIL %s: unexpected event %0d, actual %h expected none", req, kind, got);
    end else begin
      k = exp_kind.pop_front();
      d = exp_data.pop_front();
      if (k != kind || d != got) begin
        errors++;
        $display("FAIL %s: event %0d data %h, expected event %0d data %h", req, kind, got, k, d);
      end
    end
  endtask

  task automatic expect_eq(input logic [511:0] act, input logic [511:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: sample between edges and compare against the scoreboard queue.
  always @(negedge clk) if (rst_n) begin
    if (head_pop) begin
      sb_compare(1, 512'(dest_inv_idx), "R2");
      expect_eq({ckpt_save, dest_inv_valid}, 2'b11, "R2");
    end
    if (flush_pipe || clear_inv || flush_ra_cache)
      sb_compare(2, 512'({flush_pipe, clear_inv, flush_ra_cache}), "R6");
    if (restore_valid) sb_compare(3, 512'({restore_regs, restore_ghr, restore_ras}), "R7");
    if (redirect_valid) begin
      sb_compare(4, 512'(redirect_pc), "R8");
      expect_eq({runahead_mode, ckpt_valid}, 2'b10, "R9");
    end
  end

  task automatic episode(input logic [31:0] pc, input logic [31:0] addr, input logic [5:0] tag,
                         input logic [4:0] dest, input logic [31:0] seed, input int n_bad,
                         input bit collide);
    logic [255:0] r;
    logic [15:0]  g;
    logic [127:0] s;
    r = {8{seed}} ^ {8{32'h5a5a_0101}};
    g = seed[15:0] ^ 16'hc3c3;
    s = {4{~seed}};
    @(posedge clk) #1;
    head_valid = 1; head_is_load = 1; head_l2_miss = 1;
    head_pc = pc; head_addr = addr; head_tag = tag; head_dest = dest;
    arch_regs_in = r; ghr_in = g; ras_in = s;
    exp_kind.push_back(1); exp_data.push_back(512'(dest));
    if (collide) begin fill_valid = 1; fill_tag = tag; end  // R5: same-cycle fill ignored
    @(posedge clk) #1;
    fill_valid = 0;
    arch_regs_in = ~r; ghr_in = ~g; ras_in = ~s;
    head_dest = dest + 5'd1; head_addr = addr + 32'd64;      // R10: head still shows a miss
    @(negedge clk);
    expect_eq(512'(runahead_mode), 1, "R9");
    expect_eq(512'(ckpt_valid), 1, "R3");
    expect_eq(512'(miss_addr), 512'(addr), "R4");
    for (int i = 0; i < n_bad; i++) begin
      @(posedge clk) #1; fill_valid = 1; fill_tag = tag ^ 6'(i + 1);
    end
    @(posedge clk) #1; fill_valid = 0;
    @(negedge clk);
    expect_eq(512'(runahead_mode), 1, "R5");
    expect_eq(512'(miss_addr), 512'(addr), "R4");
    exp_kind.push_back(2); exp_data.push_back(512'(3'b111));
    exp_kind.push_back(3); exp_data.push_back(512'({r, g, s}));
    exp_kind.push_back(4); exp_data.push_back(512'(pc));
    @(posedge clk) #1; fill_valid = 1; fill_tag = tag;     // R10: head miss still asserted here
    @(posedge clk) #1; fill_valid = 0; head_valid = 0;
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    expect_eq(512'(runahead_mode), 0, "R9");
    expect_eq(512'(ckpt_valid), 0, "R3");
    expect_eq(512'(exp_kind.size()), 0, "R8");
  endtask

  bit done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R11: reset state
    expect_eq(512'({runahead_mode, ckpt_valid, flush_pipe, restore_valid, redirect_valid}), 0, "R11");
    // R1: a load that hits, and a missing non-load, must not start an episode
    @(posedge clk) #1; head_valid = 1; head_is_load = 1; head_l2_miss = 0;
    @(posedge clk) #1; head_is_load = 0; head_l2_miss = 1;
    @(posedge clk) #1; head_valid = 0; head_is_load = 1;
    @(posedge clk) #1; head_valid = 0;
    @(negedge clk);
    expect_eq(512'({runahead_mode, ckpt_valid}), 0, "R1");
    episode(32'h0000_1000, 32'h8000_0040, 6'h05, 5'd3, 32'h1111_2222, 0, 0);
    episode(32'h0000_2468, 32'h8000_1f80, 6'h2a, 5'd17, 32'hdead_beef, 3, 0);
    episode(32'hffff_fffc, 32'hffff_ffc0, 6'h3f, 5'd31, 32'h0f0f_f0f0, 2, 1);
    episode(32'h0000_0000, 32'h0000_0000, 6'h00, 5'd0, 32'h7654_3210, 0, 1);
    // R11: reset in the middle of an episode clears everything
    @(posedge clk) #1; head_valid = 1; head_is_load = 1; head_l2_miss = 1; head_dest = 5'd9;
    exp_kind.push_back(1); exp_data.push_back(512'(5'd9));
    @(posedge clk) #1; head_valid = 0; rst_n = 0;
    @(posedge clk) #1; rst_n = 1;
    @(negedge clk);
    expect_eq(512'({runahead_mode, ckpt_valid}), 0, "R11");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule